// File: doc/BRIEF.md
# Banked Masked System Register File

This block holds the system-control registers of a small multithreaded core. A register is addressed by a flat index built from its register number and a select field. Every register belongs to one banking class. A global register has one copy for the whole core. A per-element register has one copy for each virtual processing element. A per-thread register has one copy for each thread context. An access names a thread, and the block uses that thread to pick the copy.

Software writes go through a write mask that each copy keeps. Only the bits set in the mask change, and the other bits keep their stored value. A raw write path ignores the mask and is meant for initialisation and hardware updates. A third port reprograms the mask of one copy. Reads are combinational from the stored state. Writes and mask updates take effect at the rising clock edge. Reset is synchronous and active low.

Top module: `sysreg_bank`

## Requirements
- R1: The flat index is register number times 8 plus select, and its low 3 bits are the select. The implemented indices are: Index 0 (global), Random 8 (global), EntryLo0 16 (global), ThreadBind 18 (per-thread), EntryLo1 24 (global), Context 32 (global), PageMask 40 (global), Status 96 (per-thread), Cause 104 (global), ProcId 120 (global), ExcBase 121 (per-element), Config 128 (global), Config1 129 (global) and Config3 131 (global). No implemented register uses select 7.
- R2: A masked write stores (new AND mask) OR (old AND NOT mask) into the selected copy.
- R3: When `wr_raw` is 1, the write stores the full `wr_data` with no masking.
- R4: For a per-thread register, the copy is picked by the requesting thread ID. A write from one thread leaves every other thread's copy unchanged.
- R5: For a per-element register, the copy is picked by the low log2(NUM_VPE) bits of the requesting thread's ThreadBind copy.
- R6: A global register has one copy, and every thread ID reaches that same copy.
- R7: After reset every stored value is 0, with three exceptions: Status is 0x00400004 (bits 2 and 22 set), Random is 63, and ExcBase is 0x80000000.
- R8: Reset masks are 0xFF78FF17 for Status, 0x08C00300 for Cause, 0x7FFF0007 for Config, 0x3FFFF000 for ExcBase, 0x7FFFFFFF for Index, 0x3FFFFFFF for both EntryLo registers, 0xFF800000 for Context and 0x1FFFF800 for PageMask. ThreadBind resets to an all-ones mask.
- R9: The mask port replaces the mask of the one copy that `mk_idx` and `mk_tid` select, using the same bank choice as a data access. The new mask governs later masked writes.
- R10: A read of an unimplemented index returns 0. A write to one changes no implemented register.
- R11: A read in the same cycle as a write to the same copy returns the old value. The new value is visible from the next cycle.
- R12: ProcId, Config1, Config3 and Random reset with mask 0. Masked writes leave them unchanged, and only raw writes can alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 8 | Read flat index |
| rd_tid | input | TW | Read requesting thread |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_raw | input | 1 | 1: unmasked write, 0: masked write |
| wr_idx | input | 8 | Write flat index |
| wr_tid | input | TW | Write requesting thread |
| wr_data | input | 32 | Write data |
| mk_en | input | 1 | Mask update strobe |
| mk_idx | input | 8 | Mask update flat index |
| mk_tid | input | TW | Mask update requesting thread |
| mk_data | input | 32 | New mask value |

## Verification
The bench checks that a masked write keeps bits outside the mask, including old 1s under a 0 mask bit. A design that wrote the masked value alone would clear those bits. It rebinds a thread to the other processing element and checks that the same thread now reads a different ExcBase copy. A design that banked by thread ID would miss this. It also writes to select-7 and neighbouring indices, where a decoder that dropped index bits would alias onto a real register. It reads during a write to confirm the old value is returned, which catches any write-through path.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int NUM_TC  = 4,
  parameter int NUM_VPE = 2,
  parameter int TW      = $clog2(NUM_TC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rd_idx,
  input  logic [TW-1:0] rd_tid,
  output logic [31:0]   rd_data,
  input  logic          wr_en,
  input  logic          wr_raw,
  input  logic [7:0]    wr_idx,
  input  logic [TW-1:0] wr_tid,
  input  logic [31:0]   wr_data,
  input  logic          mk_en,
  input  logic [7:0]    mk_idx,
  input  logic [TW-1:0] mk_tid,
  input  logic [31:0]   mk_data
);
  localparam int NREG = 14;
  localparam int NCP  = (NUM_TC > NUM_VPE) ? NUM_TC : NUM_VPE;
  localparam int VW   = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1;
  localparam int BIND = 3;
  localparam logic [1:0] C_GLB = 2'd0, C_VPE = 2'd1, C_TC = 2'd2;

  localparam logic [7:0] R_IDX [NREG] = '{
    8'd0, 8'd8, 8'd16, 8'd18, 8'd24, 8'd32, 8'd40,
    8'd96, 8'd104, 8'd120, 8'd121, 8'd128, 8'd129, 8'd131};
  localparam logic [1:0] R_CLS [NREG] = '{
    C_GLB, C_GLB, C_GLB, C_TC, C_GLB, C_GLB, C_GLB,
    C_TC, C_GLB, C_GLB, C_VPE, C_GLB, C_GLB, C_GLB};
  localparam logic [31:0] R_RST [NREG] = '{
    32'h0, 32'd63, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0040_0004, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] R_MSK [NREG] = '{
    32'h7FFF_FFFF, 32'h0, 32'h3FFF_FFFF, 32'hFFFF_FFFF, 32'h3FFF_FFFF,
    32'hFF80_0000, 32'h1FFF_F800, 32'hFF78_FF17, 32'h08C0_0300,
    32'h0, 32'h3FFF_F000, 32'h7FFF_0007, 32'h0, 32'h0};

  logic [31:0] dat [NREG][NCP];
  logic [31:0] msk [NREG][NCP];

  function automatic int pick(input logic [1:0] cls, input int t, input logic [VW-1:0] bnd);
    if (cls == C_TC)  return t;
    if (cls == C_VPE) return int'(bnd);
    return 0;
  endfunction

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == R_IDX[k])
        rd_data = dat[k][pick(R_CLS[k], int'(rd_tid), dat[BIND][int'(rd_tid)][VW-1:0])];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++)
        for (int c = 0; c < NCP; c++) begin
          dat[k][c] <= R_RST[k];
          msk[k][c] <= R_MSK[k];
        end
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (wr_en && wr_idx == R_IDX[k])
          dat[k][pick(R_CLS[k], int'(wr_tid), dat[BIND][int'(wr_tid)][VW-1:0])] <= wr_raw ? wr_data :
            (wr_data & msk[k][pick(R_CLS[k], int'(wr_tid), dat[BIND][int'(wr_tid)][VW-1:0])]) |
            (dat[k][pick(R_CLS[k], int'(wr_tid), dat[BIND][int'(wr_tid)][VW-1:0])] &
             ~msk[k][pick(R_CLS[k], int'(wr_tid), dat[BIND][int'(wr_tid)][VW-1:0])]);
        if (mk_en && mk_idx == R_IDX[k])
          msk[k][pick(R_CLS[k], int'(mk_tid), dat[BIND][int'(mk_tid)][VW-1:0])] <= mk_data;
      end
    end
  end
endmodule

module sysreg_bank_chk #(
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    rd_idx,
  input logic [TW-1:0] rd_tid,
  input logic [31:0]   rd_data,
  input logic          wr_en,
  input logic          wr_raw,
  input logic [7:0]    wr_idx,
  input logic [TW-1:0] wr_tid,
  input logic [31:0]   wr_data
);
  a_r10_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[2:0] == 3'd7) |-> (rd_data == 32'h0));

  // R11, R12: with no write in the previous cycle, a steady read address sees steady data
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_idx) && $stable(rd_tid)) |-> $stable(rd_data));

  a_r3_raw_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && wr_en && wr_raw && wr_idx == 8'd0) && rd_idx == 8'd0) |-> (rd_data == $past(wr_data)));

  a_r4_thread_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && wr_en && wr_idx == 8'd96 && rd_idx == 8'd96 && wr_tid != rd_tid) &&
     rd_idx == 8'd96 && $stable(rd_tid)) |-> $stable(rd_data));
endmodule

bind sysreg_bank sysreg_bank_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_tid(rd_tid), .rd_data(rd_data),
  .wr_en(wr_en), .wr_raw(wr_raw), .wr_idx(wr_idx), .wr_tid(wr_tid), .wr_data(wr_data));

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rd_idx = '0, wr_idx = '0, mk_idx = '0;
  logic [1:0] rd_tid = '0, wr_tid = '0, mk_tid = '0;
  logic [31:0] rd_data, wr_data = '0, mk_data = '0;
  logic wr_en = 1'b0, wr_raw = 1'b0, mk_en = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sysreg_bank #(.NUM_TC(4), .NUM_VPE(2)) uut (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_tid(rd_tid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_raw(wr_raw), .wr_idx(wr_idx), .wr_tid(wr_tid), .wr_data(wr_data),
    .mk_en(mk_en), .mk_idx(mk_idx), .mk_tid(mk_tid), .mk_data(mk_data));

  typedef struct packed {
    logic [1:0]  op;   // 0 none, 1 masked, 2 raw
    logic [7:0]  wi;
    logic [1:0]  wt;
    logic [31:0] wd;
    logic [7:0]  ri;
    logic [1:0]  rt;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd96,  2'd0, 32'h0040_0004, 4'd7},  // R7
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd8,   2'd0, 32'd63,        4'd7},  // R7
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd121, 2'd0, 32'h8000_0000, 4'd7},  // R7
    '{2'd1, 8'd0,   2'd0, 32'hFFFF_FFFF, 8'd0,   2'd0, 32'h7FFF_FFFF, 4'd2},  // R2
    '{2'd1, 8'd0,   2'd0, 32'h0,         8'd0,   2'd0, 32'h0,         4'd2},  // R2
    '{2'd2, 8'd0,   2'd0, 32'hFFFF_FFFF, 8'd0,   2'd0, 32'hFFFF_FFFF, 4'd3},  // R3
    '{2'd1, 8'd0,   2'd0, 32'h0,         8'd0,   2'd0, 32'h8000_0000, 4'd2},  // R2
    '{2'd1, 8'd8,   2'd0, 32'h1234_5678, 8'd8,   2'd0, 32'd63,        4'd12}, // R12
    '{2'd1, 8'd104, 2'd0, 32'hFFFF_FFFF, 8'd104, 2'd0, 32'h08C0_0300, 4'd8},  // R8
    '{2'd1, 8'd128, 2'd0, 32'hFFFF_FFFF, 8'd128, 2'd0, 32'h7FFF_0007, 4'd8},  // R8
    '{2'd1, 8'd96,  2'd1, 32'hFFFF_FFFF, 8'd96,  2'd1, 32'hFF78_FF17, 4'd8},  // R8
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd96,  2'd0, 32'h0040_0004, 4'd4},  // R4
    '{2'd1, 8'd96,  2'd2, 32'h0,         8'd96,  2'd2, 32'h0,         4'd4},  // R4
    '{2'd1, 8'd121, 2'd0, 32'hFFFF_FFFF, 8'd121, 2'd0, 32'hBFFF_F000, 4'd8},  // R8
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd121, 2'd1, 32'hBFFF_F000, 4'd5},  // R5
    '{2'd1, 8'd18,  2'd1, 32'h1,         8'd18,  2'd1, 32'h1,         4'd4},  // R4
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd121, 2'd1, 32'h8000_0000, 4'd5},  // R5
    '{2'd1, 8'd121, 2'd1, 32'h0000_1000, 8'd121, 2'd1, 32'h8000_1000, 4'd5},  // R5
    '{2'd0, 8'd0,   2'd0, 32'h0,         8'd121, 2'd0, 32'hBFFF_F000, 4'd5},  // R5
    '{2'd1, 8'd16,  2'd3, 32'hFFFF_FFFF, 8'd16,  2'd0, 32'h3FFF_FFFF, 4'd6},  // R6
    '{2'd1, 8'd32,  2'd0, 32'hFFFF_FFFF, 8'd32,  2'd2, 32'hFF80_0000, 4'd6},  // R6
    '{2'd1, 8'd40,  2'd1, 32'hFFFF_FFFF, 8'd40,  2'd3, 32'h1FFF_F800, 4'd8},  // R8
    '{2'd2, 8'd120, 2'd0, 32'hABCD_0001, 8'd120, 2'd0, 32'hABCD_0001, 4'd1},  // R1
    '{2'd1, 8'd120, 2'd0, 32'h0,         8'd120, 2'd0, 32'hABCD_0001, 4'd12}, // R12
    '{2'd1, 8'd7,   2'd0, 32'hFF,        8'd7,   2'd0, 32'h0,         4'd10}, // R10
    '{2'd1, 8'd129, 2'd0, 32'hFFFF_FFFF, 8'd129, 2'd0, 32'h0,         4'd12}, // R12
    '{2'd1, 8'd24,  2'd2, 32'h0000_FFFF, 8'd24,  2'd1, 32'h0000_FFFF, 4'd8}   // R8
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic raw, input logic [7:0] i, input logic [1:0] t, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_raw = raw; wr_idx = i; wr_tid = t; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_raw = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, input logic [1:0] t, input int rq, input logic [31:0] exp);
    @(negedge clk);
    rd_idx = i; rd_tid = t;
    #1 chk(rq, rd_data, exp);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'd131, 2'd0, 7, 32'h0);          // R7 Config3 resets to 0
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].op != 2'd0) wr(VEC[v].op == 2'd2, VEC[v].wi, VEC[v].wt, VEC[v].wd);
      rd(VEC[v].ri, VEC[v].rt, int'(VEC[v].rq), VEC[v].ex);
    end
    // R11: read during write returns old value, new value next cycle
    @(negedge clk);
    rd_idx = 8'd0; rd_tid = 2'd0;
    wr_en = 1'b1; wr_raw = 1'b1; wr_idx = 8'd0; wr_tid = 2'd0; wr_data = 32'h1111_1111;
    #1 chk(11, rd_data, 32'h8000_0000);
    @(negedge clk);
    wr_en = 1'b0; wr_raw = 1'b0;
    #1 chk(11, rd_data, 32'h1111_1111);
    // R10: write to a neighbouring unimplemented index does not alias onto Index
    wr(1'b1, 8'd1, 2'd0, 32'h0F0F_0F0F);
    rd(8'd0, 2'd0, 10, 32'h1111_1111);
    rd(8'd1, 2'd0, 10, 32'h0);
    // R9: open Random's mask, then a masked write lands
    @(negedge clk);
    mk_en = 1'b1; mk_idx = 8'd8; mk_tid = 2'd0; mk_data = 32'h0000_FFFF;
    @(negedge clk);
    mk_en = 1'b0;
    wr(1'b0, 8'd8, 2'd0, 32'hFFFF_0005);
    rd(8'd8, 2'd0, 9, 32'h0000_0005);
    // R9: closing the mask of thread 3's Status copy only
    @(negedge clk);
    mk_en = 1'b1; mk_idx = 8'd96; mk_tid = 2'd3; mk_data = 32'h0;
    @(negedge clk);
    mk_en = 1'b0;
    wr(1'b0, 8'd96, 2'd3, 32'hFFFF_FFFF);
    rd(8'd96, 2'd3, 9, 32'h0040_0004);
    wr(1'b0, 8'd96, 2'd0, 32'hFFFF_FFFF);
    rd(8'd96, 2'd0, 9, 32'hFF78_FF17);
    // R12: raw write still alters a read-only register
    wr(1'b1, 8'd131, 2'd0, 32'h0000_00A5);
    rd(8'd131, 2'd0, 12, 32'h0000_00A5);
    // R7: reset restores values
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'd0, 2'd0, 7, 32'h0);
    rd(8'd8, 2'd0, 7, 32'd63);
    rd(8'd18, 2'd1, 7, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule